// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge and Poll Path

This block holds the request and in-service state of two cascaded 8-line interrupt controllers, 16 request lines in total, and provides the paths that take a request out of service. The first chip is the master. The second chip is the slave, and its interrupt output feeds master line 2. An acknowledge strobe returns a 4-bit line number. It asks the master first. When the master's winner is the cascade line, it asks the slave as well.

Each chip also supports a single-shot poll. After a poll is armed, the next status read of that chip returns the winning line number, or 7 when nothing is pending, and takes that line out of the request and in-service registers. Each chip has a byte-wide edge/level selection register. Only the bits in a fixed per-chip mask can be written.

Mask, priority base, in-service marking, poll arming and read-select writes come from command decoding outside this block.

Top module: `dual_pic_ack`

## Requirements
- R1: After reset, the following hold: IRR and ISR are 0 on both chips, both edge/level registers are 0, both chips' read-select is IRR, no poll is armed, `int_out` is 0, a status read returns 0, and `ack_num` reads 7.
- R2: The edge/level bit of a line selects how its request is latched. With the bit at 0 (edge), IRR sets on a 0→1 change of `req_in` between consecutive clocks. With the bit at 1 (level), IRR is set while `req_in` is high and cleared while it is low. Master bit 2 of `req_in` (`req_in[2]`) has no effect. Master IRR bit 2 follows the slave's interrupt output.
- R3: Each chip ranks its lines by (line − top) mod 8, where `top` is that chip's priority base and rank 0 is the highest priority. The winner is the unmasked requested line of lowest rank. That winner is valid only if its rank is strictly lower than the rank of every in-service line.
- R4: `int_out` is 1 exactly when the master has a valid winner.
- R5: On `ack`, if the master winner w is not 2, then `ack_num` = w, and bit w is cleared in the master's IRR and ISR.
- R6: On `ack`, if the master winner is 2, the slave is asked. `ack_num` = 8 + s, where s is the slave winner. Bit s is cleared in the slave's IRR and ISR, and bit 2 is cleared in the master's IRR and ISR. If the slave has no winner, `ack_num` = 15.
- R7: On `ack` with no master winner, `ack_num` = 7.
- R8: Every `ack` forces the master's read-select to ISR.
- R9: A status read with no poll armed returns IRR when the chip's read-select is 0 and ISR when it is 1. The read-select is written through `sel_we` with the value on `sel_isr`.
- R10: When a poll is armed on a chip (`poll_arm[0]` for the master, `poll_arm[1]` for the slave), the next status read of that chip does the following:
  - it returns the winner number, or 7 if the chip has no winner;
  - it clears the winner bit in that chip's IRR and ISR;
  - it disarms the poll.
  A slave poll that returns a line also clears bit 2 in the master's IRR and ISR.
- R11: A write to the edge/level register stores the written data ANDed with 0xF8 for the master (`lvl_sel` = 0) or with 0xDE for the slave (`lvl_sel` = 1). `lvl_rdata` returns the stored value of the selected chip.
- R12: Two same-cycle cases are resolved as follows. If a line sees a new edge or a high level in the same cycle that a poll or acknowledge clears it, the line stays set in IRR. A status read in the same cycle as `ack` has no effect, so an armed poll stays armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in | input | 16 | Request lines; [7:0] go to the master, [15:8] to the slave |
| m_mask | input | 8 | Master line mask |
| s_mask | input | 8 | Slave line mask |
| m_top | input | 3 | Master highest-priority line |
| s_top | input | 3 | Slave highest-priority line |
| isr_set | input | 16 | One-cycle in-service marking; [7:0] master, [15:8] slave |
| ack | input | 1 | Acknowledge strobe |
| ack_num | output | 4 | Acknowledged line number |
| poll_arm | input | 2 | Arm a single-shot poll; bit 0 master, bit 1 slave |
| sel_we | input | 2 | Read-select write enable; bit 0 master, bit 1 slave |
| sel_isr | input | 1 | Read-select value (1 selects ISR) |
| rd_en | input | 1 | Status read strobe |
| rd_chip | input | 1 | Chip selected for the status read (1 = slave) |
| rd_data | output | 8 | Status read data |
| lvl_we | input | 1 | Edge/level register write enable |
| lvl_sel | input | 1 | Edge/level register chip select (1 = slave) |
| lvl_wdata | input | 8 | Edge/level register write data |
| lvl_rdata | output | 8 | Edge/level register read data |
| int_out | output | 1 | Interrupt output toward the processor |

## Verification
Request latching and request clearing can fall in the same cycle on the same line.

- Edge case: the bench raises an edge-mode line during the poll read that removes it.
- Level case: the bench acknowledges a level-mode line whose input is still high.

In both cases the bench then reads IRR and expects the bit to be set again.

An acknowledge can also coincide with a status read of a chip that has a poll armed. The bench gives both strobes in one cycle and expects the following read to still behave as a poll. Around these cases, sweeps over every priority base and every request pattern compare each poll result with a ranking computed arithmetically in the bench.

// File: rtl/dual_pic_ack.sv
module dual_pic_ack #(
  parameter logic [7:0] M_LVL_MASK = 8'hF8,
  parameter logic [7:0] S_LVL_MASK = 8'hDE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] req_in,
  input  logic [7:0]  m_mask,
  input  logic [7:0]  s_mask,
  input  logic [2:0]  m_top,
  input  logic [2:0]  s_top,
  input  logic [15:0] isr_set,
  input  logic        ack,
  output logic [3:0]  ack_num,
  input  logic [1:0]  poll_arm,
  input  logic [1:0]  sel_we,
  input  logic        sel_isr,
  input  logic        rd_en,
  input  logic        rd_chip,
  output logic [7:0]  rd_data,
  input  logic        lvl_we,
  input  logic        lvl_sel,
  input  logic [7:0]  lvl_wdata,
  output logic [7:0]  lvl_rdata,
  output logic        int_out
);

  localparam logic [2:0] CASC = 3'd2;
  localparam logic [7:0] CASC_BIT = 8'h01 << CASC;

  logic [7:0]  m_irr, m_isr, s_irr, s_isr, elcr_m, elcr_s;
  logic [15:0] req_q;
  logic        m_rsel, s_rsel, m_poll, s_poll;
  logic [3:0]  mw, sw;
  logic        s_int, m_do, s_do;
  logic [7:0]  m_clr, s_clr, m_hit, s_hit, m_drop, s_drop, m_nx;

  function automatic logic [3:0] pick(input logic [7:0] irr, input logic [7:0] msk,
                                      input logic [7:0] isr, input logic [2:0] top);
    logic [7:0] rq;
    int rp, ip;
    rq = irr & ~msk;
    rp = 8;
    ip = 8;
    for (int k = 7; k >= 0; k--) begin
      if (rq[3'(top + 3'(k))]) rp = k;
      if (isr[3'(top + 3'(k))]) ip = k;
    end
    return (rp < ip) ? {1'b1, 3'(top + 3'(rp))} : 4'd0;
  endfunction

  assign mw      = pick(m_irr, m_mask, m_isr, m_top);
  assign sw      = pick(s_irr, s_mask, s_isr, s_top);
  assign s_int   = sw[3];
  assign int_out = mw[3];

  assign m_do = ack | (rd_en & ~rd_chip & m_poll & ~ack);
  assign s_do = (ack & mw[3] & (mw[2:0] == CASC)) | (rd_en & rd_chip & s_poll & ~ack);

  always_comb begin
    m_clr = '0;
    s_clr = '0;
    if (m_do && mw[3]) m_clr[mw[2:0]] = 1'b1;
    if (s_do && sw[3]) begin
      s_clr[sw[2:0]] = 1'b1;
      m_clr[CASC]    = 1'b1;
    end
  end

  assign ack_num = !mw[3]           ? 4'd7 :
                   (mw[2:0] != CASC) ? {1'b0, mw[2:0]} :
                   sw[3]             ? {1'b1, sw[2:0]} : 4'd15;

  always_comb begin
    if (rd_chip)
      rd_data = s_poll ? {5'd0, sw[3] ? sw[2:0] : 3'd7} : (s_rsel ? s_isr : s_irr);
    else
      rd_data = m_poll ? {5'd0, mw[3] ? mw[2:0] : 3'd7} : (m_rsel ? m_isr : m_irr);
  end

  assign lvl_rdata = lvl_sel ? elcr_s : elcr_m;

  assign m_hit  = (elcr_m & req_in[7:0])  | (~elcr_m & req_in[7:0]  & ~req_q[7:0]);
  assign s_hit  = (elcr_s & req_in[15:8]) | (~elcr_s & req_in[15:8] & ~req_q[15:8]);
  assign m_drop = elcr_m & ~req_in[7:0];
  assign s_drop = elcr_s & ~req_in[15:8];
  assign m_nx   = (m_irr & ~m_clr & ~m_drop) | m_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      m_irr  <= '0;
      s_irr  <= '0;
      m_isr  <= '0;
      s_isr  <= '0;
      elcr_m <= '0;
      elcr_s <= '0;
      m_rsel <= 1'b0;
      s_rsel <= 1'b0;
      m_poll <= 1'b0;
      s_poll <= 1'b0;
    end else begin
      req_q <= req_in;
      m_irr <= (m_nx & ~CASC_BIT) | ((s_int & ~m_clr[CASC]) ? CASC_BIT : 8'h00);
      s_irr <= (s_irr & ~s_clr & ~s_drop) | s_hit;
      m_isr <= (m_isr & ~m_clr) | isr_set[7:0];
      s_isr <= (s_isr & ~s_clr) | isr_set[15:8];
      if (poll_arm[0]) m_poll <= 1'b1;
      else if (rd_en && !rd_chip && !ack) m_poll <= 1'b0;
      if (poll_arm[1]) s_poll <= 1'b1;
      else if (rd_en && rd_chip && !ack) s_poll <= 1'b0;
      if (ack) m_rsel <= 1'b1;
      else if (sel_we[0]) m_rsel <= sel_isr;
      if (sel_we[1]) s_rsel <= sel_isr;
      if (lvl_we) begin
        if (lvl_sel) elcr_s <= lvl_wdata & S_LVL_MASK;
        else         elcr_m <= lvl_wdata & M_LVL_MASK;
      end
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (m_irr == 8'h00 && s_irr == 8'h00 && m_isr == 8'h00 && s_isr == 8'h00 &&
                elcr_m == 8'h00 && elcr_s == 8'h00 && !m_poll && !s_poll));

  assert_int_has_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((m_irr & ~m_mask) != 8'h00));

  assert_ack_clears_master_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_out && !ack_num[3] && isr_set == 16'h0000)
      |=> (((m_isr >> $past(ack_num[2:0])) & 8'h01) == 8'h00));

  assert_ack_clears_slave_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && ack_num[3] && ack_num != 4'd15 && isr_set == 16'h0000)
      |=> ((((s_isr >> $past(ack_num[2:0])) & 8'h01) == 8'h00) && !m_isr[CASC]));

  assert_ack_selects_isr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> m_rsel);

  assert_poll_single_shot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_chip && m_poll && !ack && !poll_arm[0]) |=> !m_poll);

  assert_slave_lvl_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_we && lvl_sel) |=> (elcr_s == ($past(lvl_wdata) & S_LVL_MASK)));

endmodule

// File: tb/test_dual_pic_ack.sv
`timescale 1ns/1ps
module test_dual_pic_ack;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req_in = '0;
  logic [7:0]  m_mask = '0, s_mask = '0;
  logic [2:0]  m_top = '0, s_top = '0;
  logic [15:0] isr_set = '0;
  logic        ack = 1'b0;
  logic [3:0]  ack_num;
  logic [1:0]  poll_arm = '0, sel_we = '0;
  logic        sel_isr = 1'b0, rd_en = 1'b0, rd_chip = 1'b0;
  logic [7:0]  rd_data;
  logic        lvl_we = 1'b0, lvl_sel = 1'b0;
  logic [7:0]  lvl_wdata = '0;
  logic [7:0]  lvl_rdata;
  logic        int_out;

  int checks = 0;
  int fails = 0;

  dual_pic_ack i_dual_pic_ack (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .m_mask(m_mask), .s_mask(s_mask),
    .m_top(m_top), .s_top(s_top), .isr_set(isr_set), .ack(ack), .ack_num(ack_num),
    .poll_arm(poll_arm), .sel_we(sel_we), .sel_isr(sel_isr), .rd_en(rd_en),
    .rd_chip(rd_chip), .rd_data(rd_data), .lvl_we(lvl_we), .lvl_sel(lvl_sel),
    .lvl_wdata(lvl_wdata), .lvl_rdata(lvl_rdata), .int_out(int_out));

  always #2.5 clk = ~clk;

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int best(input logic [7:0] p, input int top);
    for (int k = 0; k < 8; k++)
      if (p[(top + k) % 8]) return (top + k) % 8;
    return 7;
  endfunction

  task automatic do_reset;
    rst_n = 1'b0;
    step;
    step;
    rst_n = 1'b1;
    step;
  endtask

  task automatic load(input logic [15:0] p);
    req_in = p;
    step;
    req_in = '0;
  endtask

  task automatic poll(input logic chip, output logic [7:0] v);
    poll_arm = chip ? 2'b10 : 2'b01;
    step;
    poll_arm = 2'b00;
    rd_en = 1'b1;
    rd_chip = chip;
    #1 v = rd_data;
    step;
    rd_en = 1'b0;
    rd_chip = 1'b0;
  endtask

  task automatic read(input logic chip, output logic [7:0] v);
    rd_en = 1'b1;
    rd_chip = chip;
    #1 v = rd_data;
    step;
    rd_en = 1'b0;
    rd_chip = 1'b0;
  endtask

  task automatic set_sel(input logic [1:0] which, input logic isr);
    sel_we = which;
    sel_isr = isr;
    step;
    sel_we = '0;
    sel_isr = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v, model;
    do_reset;
    // r1_ reset state
    chk("R1 int_out", int_out, 0);
    chk("R1 ack_num", ack_num, 7);
    read(1'b0, v); chk("R1 master IRR", v, 0);
    read(1'b1, v); chk("R1 slave IRR", v, 0);
    lvl_sel = 1'b0; #1 chk("R1 master level reg", lvl_rdata, 0);
    lvl_sel = 1'b1; #1 chk("R1 slave level reg", lvl_rdata, 0);
    lvl_sel = 1'b0;

    // R3 R10 R2: every base, every pattern, polled out in priority order
    for (int base = 0; base < 8; base++) begin
      m_top = 3'(base);
      for (int pat = 0; pat < 256; pat++) begin
        load({8'h00, 8'(pat)});
        model = 8'(pat) & 8'hFB;
        chk("R4 int_out after load", int_out, (model != 0) ? 1 : 0);
        while (model != 0) begin
          poll(1'b0, v);
          chk("R3 R10 poll order", v, best(model, base));
          model[best(model, base)] = 1'b0;
        end
        poll(1'b0, v);
        chk("R10 empty poll", v, 7);
      end
    end

    // R3 mask sweep
    m_top = 3'd3;
    for (int pat = 0; pat < 256; pat++) begin
      m_mask = 8'h5A;
      load({8'h00, 8'(pat)});
      model = 8'(pat) & 8'hFB & ~8'h5A;
      chk("R3 masked int_out", int_out, (model != 0) ? 1 : 0);
      poll(1'b0, v);
      chk("R3 masked poll", v, best(model, 3));
      m_mask = 8'h00;
      for (int d = 0; d < 8; d++) poll(1'b0, v);
    end
    m_top = 3'd0;

    // R3 in-service blocking
    do_reset;
    isr_set = 16'h0008; step; isr_set = '0;
    load(16'h0012);
    poll(1'b0, v); chk("R3 higher than in-service", v, 1);
    chk("R3 blocked by in-service", int_out, 0);
    poll(1'b0, v); chk("R3 blocked poll", v, 7);

    // R9 read select
    do_reset;
    load(16'h0081);
    read(1'b0, v); chk("R9 IRR read", v, 8'h81);
    isr_set = 16'h0040; step; isr_set = '0;
    set_sel(2'b01, 1'b1);
    read(1'b0, v); chk("R9 ISR read", v, 8'h40);

    // R2 level mode, ignored cascade input; R5 R8 R12
    do_reset;
    lvl_we = 1'b1; lvl_sel = 1'b0; lvl_wdata = 8'h08; step; lvl_we = 1'b0;
    load(16'h0004); step;
    chk("R2 req_in[2] ignored", int_out, 0);
    read(1'b0, v); chk("R2 req_in[2] ignored IRR", v, 0);
    req_in = 16'h0008; step;
    read(1'b0, v); chk("R2 level latch", v, 8'h08);
    ack = 1'b1; #1 chk("R5 ack master line", ack_num, 3);
    step; ack = 1'b0;
    read(1'b0, v); chk("R8 read select forced to ISR", v, 0);
    set_sel(2'b01, 1'b0);
    read(1'b0, v); chk("R12 level held through ack", v, 8'h08);
    req_in = '0; step;
    read(1'b0, v); chk("R2 level drop", v, 0);
    chk("R2 level drop int_out", int_out, 0);

    // R6 R7 cascade acknowledge
    do_reset;
    load(16'h4800); step;
    chk("R6 cascade int_out", int_out, 1);
    read(1'b0, v); chk("R6 master IRR bit 2", v, 8'h04);
    ack = 1'b1; #1 chk("R6 ack slave line 3", ack_num, 11);
    step; ack = 1'b0;
    read(1'b1, v); chk("R6 slave IRR after ack", v, 8'h40);
    ack = 1'b1; #1 chk("R6 ack slave line 6", ack_num, 14);
    step; ack = 1'b0;
    step; step;
    chk("R6 all served", int_out, 0);
    ack = 1'b1; #1 chk("R7 ack nothing pending", ack_num, 7);
    step; ack = 1'b0;

    do_reset;
    load(16'h0200); step; step;
    s_mask = 8'hFF; ack = 1'b1; #1 chk("R6 slave vanished", ack_num, 15);
    step; ack = 1'b0; s_mask = 8'h00;

    // R10 slave poll clears master cascade bit, single shot
    do_reset;
    isr_set = 16'h0004; step; isr_set = '0;
    load(16'h0800); step;
    poll(1'b1, v); chk("R10 slave poll", v, 3);
    set_sel(2'b01, 1'b1);
    read(1'b0, v); chk("R10 master ISR bit 2 cleared", v, 0);
    read(1'b1, v); chk("R10 slave poll disarmed", v, 0);

    // R11 level register masks, all values
    do_reset;
    for (int val = 0; val < 256; val++) begin
      for (int c = 0; c < 2; c++) begin
        lvl_we = 1'b1; lvl_sel = c[0]; lvl_wdata = 8'(val);
        step;
        lvl_we = 1'b0;
        #1 chk("R11 level register", lvl_rdata, c ? (val & 8'hDE) : (val & 8'hF8));
      end
    end
    lvl_sel = 1'b0;

    // R12 read during ack, edge during clear
    do_reset;
    load(16'h0042);
    poll_arm = 2'b01; step; poll_arm = 2'b00;
    ack = 1'b1; rd_en = 1'b1; rd_chip = 1'b0;
    #1 chk("R12 ack with read", ack_num, 1);
    step; ack = 1'b0; rd_en = 1'b0;
    read(1'b0, v); chk("R12 poll still armed", v, 6);
    set_sel(2'b01, 1'b0);
    load(16'h0020);
    poll_arm = 2'b01; step; poll_arm = 2'b00;
    rd_en = 1'b1; rd_chip = 1'b0; req_in = 16'h0020;
    #1 chk("R12 poll during edge", rd_data, 5);
    step; rd_en = 1'b0; req_in = '0;
    read(1'b0, v); chk("R12 new edge kept", v, 8'h20);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule